// File: doc/BRIEF.md
# Binary-Search Oscillator Code Tracker

This block steers the control code of an on-chip oscillator toward a remote reference frequency. It never estimates the frequency error. It keeps a search window made of a large code (the low-frequency end), a small code (the high-frequency end) and a median code. At each step it asks an external edge-count unit to measure at each end of the window. It then keeps the half of the window whose end gave the smaller count. Because both counts carry the same noise offset, the comparison cancels that offset.

Oscillator frequency is inversely proportional to the code. For that reason the next median is the harmonic mean of the two window ends, not their arithmetic mean. A sequential restoring divider computes it. The search runs in three consecutive stages, coarse, first fine and second fine, and each stage starts from a window derived from the median it inherits. Each measurement request carries an accumulation length that doubles at every step, so the last step has the longest accumulation. After every code change the block holds the code for a programmable settling time before it asks for a count.

Top module: `freq_track_bsearch`

## Requirements
- R1: While reset is held and after its release, `done` is 0, `meas_req` is 0, `stage` is 0 and `osc_code` is 0.
- R2: A `start` pulse while idle or done loads `init_code` as the median. The first measurement is taken at code `init + (init >> SH0)`, and the second at `init - (init >> SH0)`.
- R3: After every new value on `osc_code`, `meas_req` stays low for at least `settle_len + 1` cycles before it rises.
- R4: `meas_req` and `osc_code` stay unchanged until `meas_ack` is seen. `meas_count` is captured in the cycle of `meas_ack`, and `meas_req` is low in the next cycle.
- R5: Each step measures the large-code end first and the small-code end second. If the second count is strictly smaller, the window becomes {median, small end}. Otherwise, including when the counts are equal, it becomes {large end, median}.
- R6: The new median is floor(2·L·S/(L+S)) of the new window ends L and S. The next step measures at those ends.
- R7: `stage` shows 0, 1 and 2 in order. Each stage runs ITERS steps. Stage s opens its window at the current median ± (median >> (SH0 + s·ITERS)).
- R8: `meas_len` equals ACC_BASE << g during a request, where g = s·ITERS + step is the index of the step across all stages.
- R9: After the last step, `done` rises with `osc_code` equal to the final median. Both hold until the next `start`, and `done` is low in the cycle after that `start`.
- R10: A `start` pulse while a search is running has no effect on the codes measured or on the result.
- R11: Adding the same constant to every returned count leaves every measured code and the final code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a search from `init_code` when idle or done |
| init_code | input | CW | Free-running oscillator code |
| settle_len | input | SETW | Settling cycles held after each code change |
| meas_req | output | 1 | Count measurement requested at `osc_code` |
| meas_len | output | LENW | Accumulation length for the requested count |
| meas_ack | input | 1 | One-cycle pulse: `meas_count` is valid |
| meas_count | input | CNTW | Accumulated edge count |
| osc_code | output | CW | Oscillator control code |
| stage | output | 2 | Current tuning stage (0 coarse, 1 first fine, 2 second fine) |
| done | output | 1 | Search complete; `osc_code` holds the result |

## Verification
The assertions assume that `settle_len` stays constant during a search. They also assume `init_code` leaves headroom, so that the widened large-code end still fits in CW bits. Finally they assume `meas_ack` arrives only while `meas_req` is high. The bench keeps its initial codes at or below 50000 for 16-bit codes and fixes the settling length before each start pulse. Its count model pulses the acknowledge once per request, after one extra held cycle. The counts come from a reciprocal frequency model with a common offset, plus one flat case that forces equal counts on every step.

// File: rtl/freq_track_bsearch.sv
module freq_track_bsearch #(
  parameter int CW       = 16,
  parameter int CNTW     = 16,
  parameter int ITERS    = 3,
  parameter int SH0      = 4,
  parameter int ACC_BASE = 16,
  parameter int LENW     = 16,
  parameter int SETW     = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CW-1:0]   init_code,
  input  logic [SETW-1:0] settle_len,
  output logic            meas_req,
  output logic [LENW-1:0] meas_len,
  input  logic            meas_ack,
  input  logic [CNTW-1:0] meas_count,
  output logic [CW-1:0]   osc_code,
  output logic [1:0]      stage,
  output logic            done
);
  localparam int NUMW = 2*CW + 1;
  localparam int DCW  = $clog2(NUMW + 1);
  localparam int ITW  = $clog2(ITERS + 1);
  localparam int GW   = $clog2(3*ITERS + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_SETTLE, S_REQ, S_DIV, S_DONE} st_t;
  st_t st;

  logic [CW-1:0]   cm, cl, ch;
  logic [CNTW-1:0] nl;
  logic            hi;
  logic [SETW-1:0] scnt;
  logic [ITW-1:0]  iter;
  logic [GW-1:0]   g;
  logic [CW:0]     rem, den;
  logic [NUMW-1:0] quo;
  logic [DCW-1:0]  dcnt;

  logic [7:0]      sh;
  logic [CW-1:0]   su_cl, su_ch, ncl, nch;
  logic            keep_hi, ge;
  logic [NUMW-1:0] num_n, q_step;
  logic [CW+1:0]   pre;
  logic            busy;

  assign sh      = 8'(SH0 + 32'(stage) * ITERS);
  assign su_cl   = cm + (cm >> sh);
  assign su_ch   = cm - (cm >> sh);
  assign keep_hi = meas_count < nl;
  assign ncl     = keep_hi ? cm : cl;
  assign nch     = keep_hi ? ch : cm;
  assign num_n   = NUMW'(ncl) * NUMW'(nch) * NUMW'(2);
  assign pre     = {rem, quo[NUMW-1]};
  assign ge      = pre >= {1'b0, den};
  assign q_step  = {quo[NUMW-2:0], ge};

  assign meas_req = (st == S_REQ);
  assign meas_len = LENW'(ACC_BASE) << g;
  assign done     = (st == S_DONE);
  assign busy     = (st != S_IDLE) && (st != S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cm <= '0; cl <= '0; ch <= '0; nl <= '0; hi <= 1'b0;
      scnt <= '0; iter <= '0; g <= '0; rem <= '0; den <= '0; quo <= '0;
      dcnt <= '0; osc_code <= '0; stage <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (start) begin
          cm <= init_code; stage <= '0; iter <= '0; g <= '0; st <= S_SETUP;
        end
        S_SETUP: begin
          cl <= su_cl; ch <= su_ch; osc_code <= su_cl;
          hi <= 1'b0; scnt <= '0; st <= S_SETTLE;
        end
        S_SETTLE: if (scnt == settle_len) st <= S_REQ; else scnt <= scnt + 1'b1;
        S_REQ: if (meas_ack) begin
          if (!hi) begin
            nl <= meas_count; hi <= 1'b1; osc_code <= ch; scnt <= '0; st <= S_SETTLE;
          end else begin
            cl <= ncl; ch <= nch; quo <= num_n;
            den <= {1'b0, ncl} + {1'b0, nch};
            rem <= '0; dcnt <= '0; st <= S_DIV;
          end
        end
        S_DIV: begin
          rem <= (CW+1)'(ge ? pre - {1'b0, den} : pre);
          quo <= q_step;
          if (dcnt == DCW'(NUMW-1)) begin
            cm <= q_step[CW-1:0];
            if (iter == ITW'(ITERS-1)) begin
              iter <= '0;
              if (stage == 2'd2) begin
                osc_code <= q_step[CW-1:0]; st <= S_DONE;
              end else begin
                stage <= stage + 1'b1; g <= g + 1'b1; st <= S_SETUP;
              end
            end else begin
              iter <= iter + 1'b1; g <= g + 1'b1;
              hi <= 1'b0; scnt <= '0; osc_code <= cl; st <= S_SETTLE;
            end
          end else dcnt <= dcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [SETW:0]   chk_run;
  logic [CW-1:0]   chk_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_run <= '0; chk_prev <= '0;
    end else begin
      chk_prev <= osc_code;
      if (osc_code != chk_prev) chk_run <= '0;
      else if (chk_run != '1) chk_run <= chk_run + 1'b1;
    end
  end

  p_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(meas_req) |-> chk_run >= {1'b0, settle_len});

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req && !meas_ack |=> meas_req && $stable(osc_code));

  p_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETTLE || st == S_REQ) |-> (ch < cl) && (ch <= cm) && (cm <= cl));

  p_stage_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stage) && $past(busy) |-> stage == $past(stage) + 2'd1);

  p_len_grow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> meas_len >= $past(meas_len));

  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(osc_code));
endmodule

// File: tb/sim_freq_track_bsearch.sv
module sim_freq_track_bsearch;
  localparam int CW = 16, CNTW = 16, ITERS = 3, SH0 = 4, ACC_BASE = 16, LENW = 16, SETW = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, meas_ack = 1'b0;
  logic [CW-1:0] init_code = '0;
  logic [SETW-1:0] settle_len = '0;
  logic [CNTW-1:0] meas_count = '0;
  logic meas_req, done;
  logic [LENW-1:0] meas_len;
  logic [CW-1:0] osc_code;
  logic [1:0] stage;

  always #4 clk = ~clk;

  freq_track_bsearch #(.CW(CW), .CNTW(CNTW), .ITERS(ITERS), .SH0(SH0), .ACC_BASE(ACC_BASE),
    .LENW(LENW), .SETW(SETW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .init_code(init_code), .settle_len(settle_len),
    .meas_req(meas_req), .meas_len(meas_len), .meas_ack(meas_ack), .meas_count(meas_count),
    .osc_code(osc_code), .stage(stage), .done(done));

  int checks = 0, errors = 0;
  int run = 0;
  logic [CW-1:0] prev_osc = '0;

  // init, target, bias, settle, flat
  localparam int NV = 6;
  localparam int VEC [NV][5] = '{
    '{30000, 31000,   0, 2, 0},
    '{30000, 31000, 500, 2, 0},
    '{40000, 38000, 100, 0, 0},
    '{20000, 20500,   7, 5, 0},
    '{25000,     0, 300, 1, 1},
    '{45000, 47000,   0, 3, 0}
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sample();
    if (osc_code != prev_osc) run = 1; else run++;
    prev_osc = osc_code;
  endtask

  function automatic longint count_of(input longint c, input longint t, input longint b, input int flat);
    longint d;
    if (flat != 0) return b;
    d = (64'd1 << 31) / c - (64'd1 << 31) / t;
    if (d < 0) d = -d;
    d = d + b;
    if (d > 65535) d = 65535;
    return d;
  endfunction

  task automatic measure(input longint exp, input int s, input int g, input int settle,
                         input longint tgt, input longint bias, input int flat,
                         input string ctag, output longint cnt);
    while (!meas_req) begin @(negedge clk); sample(); end
    chk(osc_code == exp, ctag, osc_code, exp);
    chk(stage == 2'(s), "R7 stage", stage, s);
    chk(meas_len == LENW'(ACC_BASE << g), "R8 meas_len", meas_len, ACC_BASE << g);
    chk(run >= settle + 2, "R3 settle", run, settle + 2);
    @(negedge clk); sample();
    chk(meas_req && osc_code == exp, "R4 hold", osc_code, exp);
    cnt = count_of(exp, tgt, bias, flat);
    meas_count = CNTW'(cnt); meas_ack = 1'b1;
    @(negedge clk); sample();
    meas_ack = 1'b0;
    chk(!meas_req, "R4 drop", meas_req, 0);
  endtask

  task automatic run_case(input int init, input int tgt, input int bias, input int settle,
                          input int flat, input bit poke, output longint fin);
    longint m_cm, m_cl, m_ch, nl, nh;
    int sh;
    @(negedge clk);
    init_code = CW'(init); settle_len = SETW'(settle); start = 1'b1;
    @(negedge clk);
    start = 1'b0; prev_osc = osc_code; run = 1;
    chk(!done, "R9 done low after start", done, 0);
    if (poke) begin
      start = 1'b1; init_code = CW'(init + 1000);
      @(negedge clk); sample();
      start = 1'b0;
    end
    m_cm = init;
    for (int s = 0; s < 3; s++) begin
      sh = SH0 + s*ITERS;
      m_cl = m_cm + (m_cm >> sh);
      m_ch = m_cm - (m_cm >> sh);
      for (int i = 0; i < ITERS; i++) begin
        measure(m_cl, s, s*ITERS + i, settle, tgt, bias, flat,
                (s == 0 && i == 0) ? (poke ? "R10 low end" : "R2 low end") : "R6 low end", nl);
        measure(m_ch, s, s*ITERS + i, settle, tgt, bias, flat,
                (s == 0 && i == 0) ? (poke ? "R10 high end" : "R2 high end") : "R5 high end", nh);
        if (nh < nl) m_cl = m_cm; else m_ch = m_cm;
        m_cm = (2 * m_cl * m_ch) / (m_cl + m_ch);
      end
    end
    while (!done) begin @(negedge clk); sample(); end
    chk(osc_code == m_cm, poke ? "R10 final code" : "R6 final code", osc_code, m_cm);
    chk(stage == 2'd2, "R7 final stage", stage, 2);
    fin = osc_code;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint res [NV];
    longint r;
    logic [CW-1:0] held;
    repeat (3) @(negedge clk);
    chk(!done && !meas_req && stage == 0 && osc_code == 0, "R1 in reset", osc_code, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!done && !meas_req && stage == 0 && osc_code == 0, "R1 after reset", {done, meas_req}, 0);

    for (int v = 0; v < NV; v++) begin
      run_case(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 1'b0, res[v]);
    end
    chk(res[1] == res[0], "R11 bias cancels", res[1], res[0]);

    held = osc_code;
    repeat (20) @(negedge clk);
    chk(done && osc_code == held, "R9 done hold", osc_code, held);

    run_case(VEC[3][0], VEC[3][1], VEC[3][2], VEC[3][3], 0, 1'b1, r);
    chk(r == res[3], "R10 start ignored result", r, res[3]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule